// File: doc/BRIEF.md
# Program bank translator

This block turns a CPU address in the upper 40 KiB of the address map (0x6000 to 0xFFFF) into an 8 KiB program ROM bank number. Software programs four 8-bit bank registers and one layout register through a CPU write port. The translation itself is combinational from those registers and the address being looked up. A register write changes the result from the clock edge that captures it.

The layout register picks how the 32 KiB area from 0x8000 is divided: one 32 KiB window, two 16 KiB windows, four 8 KiB windows, or four 8 KiB windows whose bank numbers are bit-reversed. The top window either follows bank register 3 or is pinned to the all-ones bank. The 0x6000 to 0x7FFF window either maps a ROM bank taken from register 3 or hands the access to work RAM. A last stage applies an AND mask and an OR offset, both supplied from outside, so that an outer-bank selector can confine the result to one game's slice of a larger ROM. In the wider layouts the mask and offset are shifted by the same amount as the bank.

The layout is held as an enumerated value with four named members: `LAY_W32`, `LAY_W16`, `LAY_W8` and `LAY_W8_REV`. A write to the layout register moves it straight to the written member; there is no other transition. The address is sorted into three named classes: `WIN_NONE` below 0x6000, `WIN_LOW` for 0x6000 to 0x7FFF, and `WIN_HIGH` from 0x8000.

Top module: `prg_bank_xlat`

## Requirements
- R1: After reset every bank register and the layout register are zero. With mask 0xFF and offset 0x00, 0x8000 gives bank 0xFC, 0xE000 gives 0xFF, and 0x6000 selects work RAM.
- R2: A write with address bits [15:11] = 0b10000 (0x8000 to 0x87FF) loads bank register `wr_addr[1:0]`. The new value shows at the output from the clock edge that captures the write; in the cycle of the write the old value still shows.
- R3: Writes to 0x8800 to 0x8FFF, and writes to 0xD000 to 0xD7FF with address bits [1:0] not zero, change nothing.
- R4: A write with address bits [15:11] = 0b11010 and bits [1:0] = 0 loads the layout register. Its bits [1:0] give the layout (0 = 32 KiB, 1 = 16 KiB, 2 = 8 KiB, 3 = reversed 8 KiB), bit 2 chooses the top-window source and bit 7 maps ROM at 0x6000.
- R5: In the 32 KiB layout the bank for address A at or above 0x8000 is `((L & (M>>2)) | (O>>2)) << 2 | A[14:13]`. L is the top-window bank, M the mask and O the offset.
- R6: In the 16 KiB layout the lower window uses register 1 and the upper uses L. The bank is `((R & (M>>1)) | (O>>1)) << 1 | A[13]`.
- R7: In the 8 KiB layout the windows at 0x8000, 0xA000 and 0xC000 use registers 0, 1 and 2, and 0xE000 uses L. The bank is `(R & M) | O`.
- R8: In the reversed layout R is reversed before masking: bits 0,1,2 move to 6,5,4, bit 3 stays, bits 4,5,6 move to 2,1,0, and bit 7 becomes 0.
- R9: L is register 3 when layout bit 2 is set and 0xFF when it is clear.
- R10: With layout bit 7 set, 0x6000 to 0x7FFF is a ROM hit. The raw bank is register 3 shifted left 2 with the low two bits set (32 KiB), shifted left 1 with bit 0 set (16 KiB), register 3 itself (8 KiB), or register 3 reversed. It is masked with the unshifted M and O and kept to 8 bits. With bit 7 clear the window is a RAM hit when work RAM exists. `rom_hit` and `ram_hit` are never both high.
- R11: Addresses below 0x6000 give no hit and bank 0. Addresses from 0x8000 always give a ROM hit.
- R12: The AND mask and OR offset act on every ROM result, with the shifts given in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | DATA_W (8) | CPU write data |
| cpu_addr | input | 16 | Address to translate |
| and_mask | input | BANK_W (8) | Outer-bank AND mask |
| or_mask | input | BANK_W (8) | Outer-bank OR offset |
| rom_hit | output | 1 | Address maps to program ROM |
| ram_hit | output | 1 | Address maps to work RAM |
| rom_bank | output | BANK_W (8) | 8 KiB ROM bank number, zero when no ROM hit |

## Verification
A register write and a lookup through the very register being written can land in the same cycle. The bench provokes this by raising the write strobe to bank register 0 while `cpu_addr` already points at 0x8000 in the 8 KiB layout. It checks that the old bank is still shown before the capturing edge and the new bank just after it. The random phase mixes writes to live, ignored and unrelated addresses with lookups under random masks. Every result is compared against a bench model built from the requirements.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;

    typedef enum logic [1:0] {
        LAY_W32    = 2'd0,
        LAY_W16    = 2'd1,
        LAY_W8     = 2'd2,
        LAY_W8_REV = 2'd3
    } layout_e;

    typedef struct packed {
        logic       rom_at_low;   // bit 7: ROM in 0x6000 window
        logic [3:0] spare;
        logic       last_prog;    // bit 2: top window follows register 3
        layout_e    layout;       // bits 1:0
    } mode_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2
    } win_e;

    localparam logic [4:0] BANK_PAGE = 5'h10;  // 0x8000-0x87FF
    localparam logic [4:0] MODE_PAGE = 5'h1A;  // 0xD000-0xD7FF

endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_xlat_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [15:0]                        wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    bank_q,
    output mode_t                              mode_q
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic             bank_wr;
    logic             mode_wr;
    logic [SEL_W-1:0] bank_sel;

    always_comb begin
        bank_sel = wr_addr[SEL_W-1:0];
        bank_wr  = wr_en && (wr_addr[15:11] == BANK_PAGE);
        mode_wr  = wr_en && (wr_addr[15:11] == MODE_PAGE) && (wr_addr[1:0] == 2'b00);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (bank_wr && (bank_sel == SEL_W'(g)))
                bank_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= mode_t'(wr_data[7:0]);
    end

endmodule

// File: rtl/prg_bit_rev.sv
module prg_bit_rev #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    assign dout[W-1] = 1'b0;
    for (genvar i = 0; i < W - 1; i++) begin : g_rev
        assign dout[i] = din[W-2-i];
    end
endmodule

// File: rtl/prg_win_map.sv
module prg_win_map
    import prg_xlat_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 8,
    parameter int NUM_REGS = 4,
    parameter bit HAS_WRAM = 1'b1
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q,
    input  mode_t                           mode_q,
    input  logic [15:0]                     cpu_addr,
    input  logic [BANK_W-1:0]               and_mask,
    input  logic [BANK_W-1:0]               or_mask,
    output logic                            rom_hit,
    output logic                            ram_hit,
    output logic [BANK_W-1:0]               rom_bank
);
    localparam int LAST_IDX = NUM_REGS - 1;

    win_e              win;
    logic [DATA_W-1:0] last_raw;
    logic [DATA_W-1:0] sel8_raw;
    logic [DATA_W-1:0] sel16_raw;
    logic [DATA_W-1:0] sel8_rev;
    logic [DATA_W-1:0] low_rev;
    logic [BANK_W-1:0] high_bank;
    logic [BANK_W-1:0] low_raw;
    logic [BANK_W-1:0] low_bank;

    always_comb begin
        last_raw  = mode_q.last_prog ? bank_q[LAST_IDX] : '1;
        sel8_raw  = (cpu_addr[14:13] == 2'd3) ? last_raw : bank_q[cpu_addr[14:13]];
        sel16_raw = cpu_addr[14] ? last_raw : bank_q[1];
    end

    prg_bit_rev #(.W(DATA_W)) u_rev_high (.din(sel8_raw),          .dout(sel8_rev));
    prg_bit_rev #(.W(DATA_W)) u_rev_low  (.din(bank_q[LAST_IDX]),  .dout(low_rev));

    // address class
    always_comb begin
        if (cpu_addr[15])
            win = WIN_HIGH;
        else if (cpu_addr[14:13] == 2'b11)
            win = WIN_LOW;
        else
            win = WIN_NONE;
    end

    // per-layout bank arithmetic
    always_comb begin
        unique case (mode_q.layout)
            LAY_W32: begin
                high_bank = (((BANK_W'(last_raw) & (and_mask >> 2)) | (or_mask >> 2)) << 2)
                          | BANK_W'(cpu_addr[14:13]);
                low_raw   = (BANK_W'(bank_q[LAST_IDX]) << 2) | BANK_W'(3);
            end
            LAY_W16: begin
                high_bank = (((BANK_W'(sel16_raw) & (and_mask >> 1)) | (or_mask >> 1)) << 1)
                          | BANK_W'(cpu_addr[13]);
                low_raw   = (BANK_W'(bank_q[LAST_IDX]) << 1) | BANK_W'(1);
            end
            LAY_W8: begin
                high_bank = (BANK_W'(sel8_raw) & and_mask) | or_mask;
                low_raw   = BANK_W'(bank_q[LAST_IDX]);
            end
            LAY_W8_REV: begin
                high_bank = (BANK_W'(sel8_rev) & and_mask) | or_mask;
                low_raw   = BANK_W'(low_rev);
            end
        endcase
        low_bank = (low_raw & and_mask) | or_mask;
    end

    // outputs by address class
    always_comb begin
        rom_hit  = 1'b0;
        ram_hit  = 1'b0;
        rom_bank = '0;
        unique case (win)
            WIN_NONE: ;
            WIN_LOW: begin
                if (mode_q.rom_at_low) begin
                    rom_hit  = 1'b1;
                    rom_bank = low_bank;
                end else begin
                    ram_hit  = HAS_WRAM;
                end
            end
            WIN_HIGH: begin
                rom_hit  = 1'b1;
                rom_bank = high_bank;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
    import prg_xlat_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 8,
    parameter bit HAS_WRAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [15:0]       cpu_addr,
    input  logic [BANK_W-1:0] and_mask,
    input  logic [BANK_W-1:0] or_mask,
    output logic              rom_hit,
    output logic              ram_hit,
    output logic [BANK_W-1:0] rom_bank
);
    localparam int NUM_REGS = 4;

    logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
    mode_t                           mode_q;

    prg_bank_regs #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bank_q (bank_q),
        .mode_q (mode_q)
    );

    prg_win_map #(
        .DATA_W  (DATA_W),
        .BANK_W  (BANK_W),
        .NUM_REGS(NUM_REGS),
        .HAS_WRAM(HAS_WRAM)
    ) u_map (
        .bank_q  (bank_q),
        .mode_q  (mode_q),
        .cpu_addr(cpu_addr),
        .and_mask(and_mask),
        .or_mask (or_mask),
        .rom_hit (rom_hit),
        .ram_hit (ram_hit),
        .rom_bank(rom_bank)
    );

endmodule

// File: rtl/prg_xlat_chk.sv
module prg_xlat_chk
    import prg_xlat_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [15:0]       cpu_addr,
    input logic [BANK_W-1:0] and_mask,
    input logic [BANK_W-1:0] or_mask,
    input logic              rom_hit,
    input logic              ram_hit,
    input logic [BANK_W-1:0] rom_bank,
    input mode_t             mode_q
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_hit_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_hit && ram_hit));

    assert_ram_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_hit |-> (cpu_addr[15:13] == 3'b011) && !mode_q.rom_at_low);

    assert_below_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] < 3'b011) |-> (!rom_hit && !ram_hit && rom_bank == '0));

    assert_upper_rom_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> rom_hit);

    assert_w32_subbank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.layout == LAY_W32 && cpu_addr[15]) |-> rom_bank[1:0] == cpu_addr[14:13]);

    assert_w16_subbank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.layout == LAY_W16 && cpu_addr[15]) |-> rom_bank[0] == cpu_addr[13]);

    assert_ignored_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en && wr_addr[15:11] == 5'h11)
         && $stable(cpu_addr) && $stable(and_mask) && $stable(or_mask))
        |-> ($stable(rom_bank) && $stable(rom_hit) && $stable(ram_hit)));

endmodule

bind prg_bank_xlat prg_xlat_chk #(.BANK_W(BANK_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cpu_addr(cpu_addr),
    .and_mask(and_mask),
    .or_mask (or_mask),
    .rom_hit (rom_hit),
    .ram_hit (ram_hit),
    .rom_bank(rom_bank),
    .mode_q  (mode_q)
);

// File: tb/sim_prg_bank_xlat.sv
module sim_prg_bank_xlat;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic [15:0] cpu_addr;
    logic [7:0]  and_mask;
    logic [7:0]  or_mask;
    logic        rom_hit;
    logic        ram_hit;
    logic [7:0]  rom_bank;

    always #10 clk = ~clk;   // 50 MHz

    prg_bank_xlat u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .and_mask(and_mask),
        .or_mask(or_mask), .rom_hit(rom_hit), .ram_hit(ram_hit),
        .rom_bank(rom_bank)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] sb [4];
    logic [7:0] sm;

    function automatic logic [7:0] rv(input logic [7:0] x);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 7; i++) r[i] = x[6-i];
        return r;
    endfunction

    // expected {rom_hit, ram_hit, bank} from requirements R4..R12
    function automatic logic [9:0] model(input logic [15:0] a, input logic [7:0] m, input logic [7:0] o);
        logic [7:0] last, r, b;
        last = sm[2] ? sb[3] : 8'hFF;
        if (a < 16'h6000) return 10'd0;
        if (a < 16'h8000) begin
            if (!sm[7]) return {2'b01, 8'h00};
            case (sm[1:0])
                2'd0: r = {sb[3][5:0], 2'b11};
                2'd1: r = {sb[3][6:0], 1'b1};
                2'd2: r = sb[3];
                default: r = rv(sb[3]);
            endcase
            return {2'b10, (r & m) | o};
        end
        case (sm[1:0])
            2'd0: begin
                b = (last & (m >> 2)) | (o >> 2);
                b = {b[5:0], a[14:13]};
            end
            2'd1: begin
                r = a[14] ? last : sb[1];
                b = (r & (m >> 1)) | (o >> 1);
                b = {b[6:0], a[13]};
            end
            default: begin
                r = (a[14:13] == 2'd3) ? last : sb[a[14:13]];
                if (sm[1:0] == 2'd3) r = rv(r);
                b = (r & m) | o;
            end
        endcase
        return {2'b10, b};
    endfunction

    task automatic cmp(input string tag, input logic [9:0] exp);
        n_chk++;
        if ({rom_hit, ram_hit, rom_bank} !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h act=%b/%b/%h exp=%b/%b/%h", tag, cpu_addr,
                     rom_hit, ram_hit, rom_bank, exp[9], exp[8], exp[7:0]);
        end
    endtask

    task automatic look(input logic [15:0] a, input logic [7:0] m, input logic [7:0] o,
                        input logic [9:0] exp, input string tag);
        cpu_addr = a; and_mask = m; or_mask = o;
        #2;
        cmp(tag, exp);
    endtask

    task automatic look_model(input logic [15:0] a, input logic [7:0] m, input logic [7:0] o);
        cpu_addr = a; and_mask = m; or_mask = o;
        #2;
        cmp("R12 random", model(a, m, o));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[15:11] == 5'h10) sb[a[1:0]] = d;
        else if (a[15:11] == 5'h1A && a[1:0] == 2'b00) sm = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        cpu_addr = '0; and_mask = 8'hFF; or_mask = 8'h00;
        for (int i = 0; i < 4; i++) sb[i] = 8'h00;
        sm = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'hFC}, "R1 reset 8000");
        look(16'hE000, 8'hFF, 8'h00, {2'b10, 8'hFF}, "R1 reset E000");
        look(16'h6000, 8'hFF, 8'h00, {2'b01, 8'h00}, "R1 reset 6000 ram");

        // R2, R4, R7 register load and 8 KiB layout
        wr(16'hD000, 8'h06);
        wr(16'h8002, 8'h15);
        look(16'hC000, 8'hFF, 8'h00, {2'b10, 8'h15}, "R2 bank2 load");
        wr(16'h8000, 8'h03); wr(16'h8001, 8'h07);
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'h03}, "R7 window 8000");
        look(16'hA000, 8'hFF, 8'h00, {2'b10, 8'h07}, "R7 window A000");

        // R3 ignored writes
        wr(16'h8802, 8'h33);
        look(16'hC000, 8'hFF, 8'h00, {2'b10, 8'h15}, "R3 mirror page ignored");
        wr(16'hD001, 8'h03);
        look(16'hC000, 8'hFF, 8'h00, {2'b10, 8'h15}, "R3 mode offset ignored");

        // R9 top window source
        wr(16'h8003, 8'h21);
        look(16'hE000, 8'hFF, 8'h00, {2'b10, 8'h21}, "R9 last from reg3");
        wr(16'hD000, 8'h02);
        look(16'hE000, 8'hFF, 8'h00, {2'b10, 8'hFF}, "R9 last forced");

        // R2 same-cycle write and lookup
        wr(16'hD000, 8'h06);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h2A;
        cpu_addr = 16'h8000; and_mask = 8'hFF; or_mask = 8'h00;
        #2 cmp("R2 old value before edge", {2'b10, 8'h03});
        @(negedge clk);
        wr_en = 1'b0; sb[0] = 8'h2A;
        #2 cmp("R2 new value after edge", {2'b10, 8'h2A});

        // R8 reversed
        wr(16'hD000, 8'h07);
        wr(16'h8000, 8'h01);
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'h40}, "R8 rev bit0");
        wr(16'h8000, 8'h80);
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'h00}, "R8 rev bit7 dropped");
        wr(16'h8001, 8'h08);
        look(16'hA000, 8'hFF, 8'h00, {2'b10, 8'h08}, "R8 rev bit3 kept");

        // R5 32 KiB layout and R12 masks
        wr(16'hD000, 8'h04);
        wr(16'h8003, 8'h05);
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'h14}, "R5 32k 8000");
        look(16'hE000, 8'hFF, 8'h00, {2'b10, 8'h17}, "R5 32k E000");
        look(16'hE000, 8'h0F, 8'h30, {2'b10, 8'h37}, "R12 32k masked");

        // R6 16 KiB layout
        wr(16'hD000, 8'h05);
        wr(16'h8001, 8'h09);
        look(16'h8000, 8'hFF, 8'h00, {2'b10, 8'h12}, "R6 16k 8000");
        look(16'hA000, 8'hFF, 8'h00, {2'b10, 8'h13}, "R6 16k A000");
        look(16'hC000, 8'hFF, 8'h00, {2'b10, 8'h0A}, "R6 16k C000");
        look(16'hE000, 8'hFF, 8'h00, {2'b10, 8'h0B}, "R6 16k E000");

        // R10 low window
        wr(16'hD000, 8'h80);
        look(16'h6000, 8'hFF, 8'h00, {2'b10, 8'h17}, "R10 low 32k");
        wr(16'hD000, 8'h81);
        look(16'h7FFF, 8'hFF, 8'h00, {2'b10, 8'h0B}, "R10 low 16k");
        wr(16'hD000, 8'h82);
        look(16'h6000, 8'hFF, 8'h00, {2'b10, 8'h05}, "R10 low 8k");
        wr(16'hD000, 8'h83);
        look(16'h6000, 8'hFF, 8'h00, {2'b10, 8'h50}, "R10 low rev");
        wr(16'hD000, 8'h00);
        look(16'h6000, 8'hFF, 8'h00, {2'b01, 8'h00}, "R10 low ram");

        // R11 below window
        look(16'h4020, 8'hFF, 8'h00, 10'd0, "R11 below 6000");

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [15:0] a;
            case ($urandom_range(0, 2))
                0: a = 16'h8000 | 16'($urandom_range(0, 16'h0FFF));
                1: a = 16'hD000 | 16'($urandom_range(0, 16'h0FFF));
                default: a = 16'($urandom);
            endcase
            wr(a, 8'($urandom));
            for (int k = 0; k < 3; k++)
                look_model(16'($urandom_range(16'h4000, 16'hFFFF)), 8'($urandom), 8'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule